// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address Counter

This block is a clocked single-port memory of 36-bit words. The words are split into four 9-bit byte lanes. A two-bit burst counter steps through four linked locations after one address is loaded. Two load strobes can start a burst:

- The processor-side strobe always opens with a read cycle.
- The controller-side strobe can load an address and write to it on the same edge.

A step input moves the burst to the next word. While that input is held inactive, the burst stays on the current word, which is how a burst is suspended.

Reads are flow-through. After the clock edge that sets the burst address, the stored word at that address is presented combinationally, with no output register stage. The block has no bidirectional pad. Instead it drives the output word together with a drive-enable flag, and the pad's tri-state buffer sits outside the block. Writes are controlled in two ways:

- A global write strobe writes all four lanes.
- A lane-write gate combined with four per-lane strobes writes only the chosen lanes.

Three chip selects of mixed polarity are sampled on the same edge as the strobes.

Top module: `burst_sram`

## Requirements
- R1: The chip is selected only when `sel0_n` is 0, `sel1` is 1 and `sel2_n` is 0 on the sampling edge. Any other combination counts as unselected.
- R2: When `ld_cpu_n` is 0 on a selected edge, `addr` is loaded as the burst address. After that edge, `rdata` shows the stored word at that address without waiting for another clock, provided `rd_en_n` is 0.
- R3: On an edge where `ld_cpu_n` starts a burst, `wr_all_n`, `wr_gate_n` and `lane_wr_n` have no effect, so no lane of any word changes.
- R4: When `ld_ctl_n` is 0 on a selected edge and `ld_cpu_n` is not active, `addr` is loaded and any write strobes on that edge write to `addr` at once.
- R5: On a burst-continue edge (an active burst with no strobe) where `step_n` is 0, the address advances in linear order. Only the two low address bits change, and they wrap from 3 back to 0; the upper bits are unchanged.
- R6: On a burst-continue edge where `step_n` is 1, the address is held. Any write on that edge goes to the held address, so the cycle after a processor-strobe load can write the just-loaded word.
- R7: When `wr_all_n` is 1 and `wr_gate_n` is 0, lane i (bits 9i+8 down to 9i) is written exactly when `lane_wr_n[i]` is 0. All other lanes keep their contents.
- R8: When `wr_all_n` is 0, all four lanes are written regardless of `wr_gate_n` and `lane_wr_n`.
- R9: `rdata_drive` is 1 only when `rd_en_n` is 0, a burst is active, and the last edge was not a write. It is 0 whenever `rd_en_n` is 1 and on the cycle after any write edge.
- R10: `ld_cpu_n` is ignored on an unselected edge, and an active burst then continues as if no strobe had come. `ld_ctl_n` on an unselected edge ends the burst, and the output stays undriven.
- R11: When both strobes are 0 on a selected edge, the processor strobe wins. The edge is a read, and the write strobes present on it are dropped.
- R12: After reset no burst is active, and `rdata_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | AW | Word address loaded by either strobe |
| ld_cpu_n | input | 1 | Processor-side load strobe, active low, read-first |
| ld_ctl_n | input | 1 | Controller-side load strobe, active low, write-capable |
| step_n | input | 1 | Burst step, active low; high holds the address |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_gate_n | input | 1 | Gate for the per-lane write strobes, active low |
| lane_wr_n | input | 4 | Per-lane write strobes, active low, bit i is lane i |
| rd_en_n | input | 1 | Output enable, active low |
| wdata | input | 36 | Write word |
| rdata | output | 36 | Flow-through read word |
| rdata_drive | output | 1 | Drive enable for the external data pad |

## Verification
The hardest case to reach is the processor-strobe load that arrives with write strobes already active, combined with the follow-on write to the same word under a held step. From the ports, the dropped first-cycle write looks just like a read. The bench therefore fills every word with a distinct pattern, asserts the write strobes together with the processor strobe, and reads the word back afterwards. It then holds `step_n` high to write the loaded word and confirms that the new data lands at that word and not at the next one. Unselected processor strobes are sent in the middle of a suspended burst, so that an ignored strobe shows up as a burst that continues.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_CPU  = 2'd1,
    CYC_CTL  = 2'd2,
    CYC_RUN  = 2'd3
  } cyc_e;

  // all three selects must agree
  function automatic logic chip_on(input logic s0_n, input logic s1, input logic s2_n);
    return (!s0_n) && s1 && (!s2_n);
  endfunction

  // lane strobe decode: global write dominates the gated per-lane strobes
  function automatic logic [LANES-1:0] lane_mask(input logic all_n, input logic gate_n,
                                                 input logic [LANES-1:0] ln_n);
    logic [LANES-1:0] m;
    if (!all_n)       m = '1;
    else if (!gate_n) m = ~ln_n;
    else              m = '0;
    return m;
  endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import burst_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             ld_cpu_n,
  input  logic             ld_ctl_n,
  input  logic             step_n,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             wr_all_n,
  input  logic             wr_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [AW-1:0]    cur_addr,
  output logic [AW-1:0]    wr_addr,
  output logic [LANES-1:0] wr_mask,
  output logic             active,
  output logic             last_wr,
  output cyc_e             cyc,
  output logic             cpu_load
);

  localparam int CNT_W = 2;

  // linear increment that wraps inside the aligned four-word block
  function automatic logic [AW-1:0] burst_next(input logic [AW-1:0] a);
    logic [CNT_W-1:0] low;
    low = a[CNT_W-1:0] + 1'b1;
    return {a[AW-1:CNT_W], low};
  endfunction

  logic            sel;
  logic            ctl_load;
  logic            ctl_drop;
  logic [AW-1:0]   eff_addr;
  logic [LANES-1:0] req_mask;
  logic            nxt_active;

  assign sel      = chip_on(sel0_n, sel1, sel2_n);
  assign req_mask = lane_mask(wr_all_n, wr_gate_n, lane_wr_n);
  assign cpu_load = !ld_cpu_n && sel;
  assign ctl_load = !cpu_load && !ld_ctl_n && sel;
  assign ctl_drop = !cpu_load && !ld_ctl_n && !sel;

  always_comb begin
    cyc        = CYC_IDLE;
    eff_addr   = cur_addr;
    wr_mask    = '0;
    nxt_active = active;
    if (cpu_load) begin
      cyc        = CYC_CPU;
      eff_addr   = addr;
      nxt_active = 1'b1;
    end else if (ctl_load) begin
      cyc        = CYC_CTL;
      eff_addr   = addr;
      wr_mask    = req_mask;
      nxt_active = 1'b1;
    end else if (ctl_drop) begin
      nxt_active = 1'b0;
    end else if (active) begin
      cyc      = CYC_RUN;
      eff_addr = step_n ? cur_addr : burst_next(cur_addr);
      wr_mask  = req_mask;
    end
  end

  assign wr_addr = eff_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      active   <= 1'b0;
      last_wr  <= 1'b0;
    end else begin
      active  <= nxt_active;
      last_wr <= |wr_mask;
      if (cyc != CYC_IDLE) cur_addr <= eff_addr;
    end
  end

  // R2
  cpu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_load |=> (active && cur_addr == $past(addr)));

  // R3
  cpu_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_CPU) |-> (wr_mask == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_RUN && step_n) |=> $stable(cur_addr));

  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_RUN) |=> (cur_addr[AW-1:CNT_W] == $past(cur_addr[AW-1:CNT_W])));

  // R10
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ctl_n && !sel && !cpu_load) |=> !active);

endmodule

// File: rtl/bsr_array.sv
module bsr_array
  import burst_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) store[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[rd_addr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              ld_cpu_n,
  input  logic              ld_ctl_n,
  input  logic              step_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              wr_all_n,
  input  logic              wr_gate_n,
  input  logic [3:0]        lane_wr_n,
  input  logic              rd_en_n,
  input  logic [35:0]       wdata,
  output logic [35:0]       rdata,
  output logic              rdata_drive
);

  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    wr_addr;
  logic [LANES-1:0] wr_mask;
  logic             active;
  logic             last_wr;
  logic             cpu_load;
  cyc_e             cyc;

  bsr_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .step_n(step_n),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n), .lane_wr_n(lane_wr_n),
    .cur_addr(cur_addr), .wr_addr(wr_addr), .wr_mask(wr_mask),
    .active(active), .last_wr(last_wr), .cyc(cyc), .cpu_load(cpu_load)
  );

  bsr_array #(.AW(AW)) u_array (
    .clk(clk), .wr_mask(wr_mask), .wr_addr(wr_addr), .wdata(wdata),
    .rd_addr(cur_addr), .rdata(rdata)
  );

  assign rdata_drive = active && !last_wr && !rd_en_n;

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |-> !rdata_drive);

  // R9
  after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_mask) |=> !rdata_drive);

  // R11
  cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && !ld_ctl_n && cpu_load) |-> (wr_mask == '0 && cyc == CYC_CPU));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !rdata_drive);

endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ld_cpu_n = 1'b1, ld_ctl_n = 1'b1, step_n = 1'b1;
  logic sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
  logic wr_all_n = 1'b1, wr_gate_n = 1'b1;
  logic [3:0] lane_wr_n = 4'hF;
  logic rd_en_n = 1'b0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic rdata_drive;

  always #4 clk = ~clk;

  burst_sram #(.AW(AW)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n),
    .step_n(step_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n), .lane_wr_n(lane_wr_n),
    .rd_en_n(rd_en_n), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [35:0]   ref_mem [DEPTH];
  logic [AW-1:0] ref_cur = '0;
  bit            ref_act = 0;
  bit            ref_lastwr = 0;

  // scoreboard queues
  bit          q_drv [$];
  logic [35:0] q_dat [$];
  string       q_tag [$];

  function automatic logic [35:0] pat(input int a);
    return {9'(a * 3 + 1), 9'(a + 100), 9'(a ^ 9'h155), 9'(a * 7 + 2)};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle and push the expected post-edge output
  task automatic cyc(input logic c_n, input logic t_n, input logic s_n, input int a,
                     input logic [35:0] d, input logic all_n, input logic g_n,
                     input logic [3:0] ln, input logic oe_n, input logic [2:0] sl,
                     input string tag);
    bit sel, p, c;
    logic [AW-1:0] eff;
    logic [3:0] m;
    @(negedge clk);
    ld_cpu_n = c_n; ld_ctl_n = t_n; step_n = s_n; addr = AW'(a); wdata = d;
    wr_all_n = all_n; wr_gate_n = g_n; lane_wr_n = ln; rd_en_n = oe_n;
    {sel0_n, sel1, sel2_n} = sl;
    sel = !sl[2] && sl[1] && !sl[0];
    p = !c_n && sel;
    c = !p && !t_n;
    m = !all_n ? 4'hF : (!g_n ? ~ln : 4'h0);
    eff = ref_cur;
    if (p) begin
      eff = AW'(a); ref_act = 1; m = 4'h0;
    end else if (c) begin
      if (sel) begin eff = AW'(a); ref_act = 1; end
      else begin ref_act = 0; m = 4'h0; end
    end else if (ref_act) begin
      if (!s_n) eff = {ref_cur[AW-1:2], 2'(ref_cur[1:0] + 2'd1)};
    end else m = 4'h0;
    for (int i = 0; i < 4; i++)
      if (m[i]) ref_mem[eff][i*9 +: 9] = d[i*9 +: 9];
    if (p || (c && sel) || ref_act) ref_cur = eff;
    ref_lastwr = (m != 0);
    q_drv.push_back(ref_act && !ref_lastwr && !oe_n);
    q_dat.push_back(ref_mem[ref_cur]);
    q_tag.push_back(tag);
  endtask

  localparam logic [2:0] ON = 3'b010;

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_drv.size() > 0) begin
        bit ed; logic [35:0] dd; string tg;
        ed = q_drv.pop_front(); dd = q_dat.pop_front(); tg = q_tag.pop_front();
        check({tg, " drive"}, {35'd0, rdata_drive}, {35'd0, ed});
        if (ed) check({tg, " data"}, rdata, dd);
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    #20;
    // R12 reset state
    check("R12 reset", {35'd0, rdata_drive}, 36'd0);
    @(negedge clk); rst_n = 1'b1;
    check("R12 after reset", {35'd0, rdata_drive}, 36'd0);

    // fill: R4 controller load write, R5 step, R8 global write, R9 quiet after writes
    for (int b = 0; b < DEPTH / 4; b++) begin
      cyc(1, 0, 1, b*4, pat(b*4), 0, 1, 4'hF, 0, ON, "R4 R8 fill load");
      for (int k = 1; k < 4; k++)
        cyc(1, 1, 0, 0, pat(b*4+k), 0, 0, 4'h0, 0, ON, "R5 R8 fill step");
    end

    // R2 R5 processor burst read with wrap from 5: 5,6,7,4,5
    cyc(0, 1, 1, 5, '0, 1, 1, 4'hF, 0, ON, "R2 load read");
    for (int k = 0; k < 4; k++) cyc(1, 1, 0, 0, '0, 1, 1, 4'hF, 0, ON, "R5 wrap read");

    // R6 suspend, and R10 unselected processor strobe ignored mid-burst
    cyc(0, 1, 1, 8, '0, 1, 1, 4'hF, 0, ON, "R2 load 8");
    cyc(1, 1, 1, 0, '0, 1, 1, 4'hF, 0, ON, "R6 hold");
    cyc(0, 1, 1, 40, '0, 1, 1, 4'hF, 0, 3'b011, "R10 ignored strobe");
    cyc(1, 1, 0, 0, '0, 1, 1, 4'hF, 0, ON, "R6 resume step");

    // R3 writes dropped on processor load
    cyc(0, 1, 1, 16, 36'hABCDE1234, 0, 0, 4'h0, 0, ON, "R3 load with writes");
    cyc(1, 1, 1, 0, '0, 1, 1, 4'hF, 0, ON, "R3 reread");

    // R6 write to just-loaded word under held step
    cyc(0, 1, 1, 20, '0, 1, 1, 4'hF, 0, ON, "R6 load 20");
    cyc(1, 1, 1, 0, 36'h123456789, 0, 1, 4'hF, 0, ON, "R6 write held");
    cyc(0, 1, 1, 20, '0, 1, 1, 4'hF, 0, ON, "R6 read 20");
    cyc(0, 1, 1, 21, '0, 1, 1, 4'hF, 0, ON, "R6 read 21 untouched");

    // R7 lane writes: lanes 0 and 2
    cyc(1, 0, 1, 12, 36'hFFFFFFFFF, 1, 0, 4'b1010, 0, ON, "R7 lane write");
    cyc(0, 1, 1, 12, '0, 1, 1, 4'hF, 0, ON, "R7 read back");
    // R8 global write ignores lane strobes
    cyc(1, 0, 1, 13, 36'h0F0F0F0F0, 0, 1, 4'hF, 0, ON, "R8 all lanes");
    cyc(0, 1, 1, 13, '0, 1, 1, 4'hF, 0, ON, "R8 read back");
    // gate inactive: no write
    cyc(1, 0, 1, 14, 36'h0, 1, 1, 4'h0, 0, ON, "R7 gate off");
    cyc(1, 1, 1, 0, '0, 1, 1, 4'hF, 0, ON, "R7 gate off read");

    // R9 output enable high
    cyc(0, 1, 1, 9, '0, 1, 1, 4'hF, 1, ON, "R9 oe high");
    cyc(1, 1, 1, 0, '0, 1, 1, 4'hF, 0, ON, "R9 oe low");

    // R1 each select alone deselects through controller strobe; R10 end burst
    cyc(1, 0, 1, 2, '0, 1, 1, 4'hF, 0, 3'b110, "R1 R10 sel0 off");
    cyc(0, 1, 1, 2, '0, 1, 1, 4'hF, 0, 3'b000, "R1 R10 sel1 off");
    cyc(0, 1, 1, 2, '0, 1, 1, 4'hF, 0, 3'b011, "R1 sel2 off");
    cyc(0, 1, 1, 2, '0, 1, 1, 4'hF, 0, ON, "R1 selected");

    // R11 both strobes: processor wins, write dropped
    cyc(0, 0, 1, 24, 36'h555555555, 0, 0, 4'h0, 0, ON, "R11 both strobes");
    cyc(1, 1, 1, 0, '0, 1, 1, 4'hF, 0, ON, "R11 reread");

    cyc(1, 1, 1, 0, '0, 1, 1, 4'hF, 0, ON, "idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule